// File: doc/BRIEF.md
# Multiplexed Bus Cycle Sequencer

This block turns one internal transfer request into a complete minimum-mode processor bus cycle on a time-shared address/data bus. The requester gives the direction (read or write), the space (memory or I/O), a 20-bit address, 16-bit write data, a high-byte enable and a 2-bit segment code. The block steps through the clock states T1, T2, T3, any number of wait states TW, and T4. It drives the shared bus lines with an output enable and drives the four upper address lines, which carry status once the address phase is over. It also produces the latch, strobe, enable, direction and space-select pins.

The shared pins carry the address in T1 and data afterwards. External logic captures the address on the falling edge of the latch enable. The `ready` input stretches the cycle with wait states. For reads, the bus value is captured on the edge that ends the last T3/TW state, and it is handed back in T4 together with a one-cycle done pulse. A new request can be taken when the block is idle or while it is in T4, so cycles can run back to back with no idle gap.

States: IDLE, T1, T2, T3, TW, T4. Transitions: IDLE to T1 on a request, IDLE to IDLE with none; T1 to T2; T2 to T3; T3 or TW to T4 when `ready` is high, to TW when it is low; T4 to T1 on a request, T4 to IDLE with none.

Top module: `bus_cycle_seq`

## Requirements
- R1: The state sequence is IDLE, T1, T2, T3, zero or more TW, T4, then T1 if `req_valid` is high in T4, otherwise IDLE. `req_ready` is high exactly in IDLE and T4, and a request is taken on the rising edge at which both `req_valid` and `req_ready` are high.
- R2: `ale` is high in T1 only. In T1, `ad_oe` is 1 and `ad_out` equals address bits 15..0.
- R3: In T1, `hi_out` carries address bits 19..16 for memory cycles and 0000 for I/O cycles. From T2 through T4 it carries status {0,0,seg}, where seg 00 = extra, 01 = stack, 10 = code or none, 11 = data. In IDLE it is 0000.
- R4: `bhe_n` equals the inverse of the high-byte enable in T1 and is 1 in every other state.
- R5: `rd_n` is low in T2, T3 and TW of read cycles, and `wr_n` is low in the same states of write cycles. They are never low together, and both are high in T1, T4 and IDLE.
- R6: `den_n` is low from T2 through T4 in write cycles and from T3 through T4 in read cycles. It is high at all other times.
- R7: `dt_r` is 1 for writes and 0 for reads, and `m_io` is 1 for memory and 0 for I/O. Both hold their value from T1 through T4 and are 0 in IDLE.
- R8: In write cycles, `ad_oe` stays 1 from T1 through T4 and `ad_out` equals the write data from T2 on. In read cycles, `ad_oe` is 1 in T1 only.
- R9: `ready` is sampled only at the edges that end T3 and TW. If it is low there, a TW state follows. Its value in T1 and T2 has no effect.
- R10: In read cycles, `rsp_data` takes `ad_in` at the edge that ends the T3 or TW state in which `ready` is high. It is valid in T4 and holds until the next read capture; write cycles leave it unchanged. It resets to 0.
- R11: `rsp_done` is high for exactly one cycle, in T4, for every cycle.
- R12: With `req_valid` high during T4, T1 of the next cycle follows immediately.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Transfer request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_mem | input | 1 | 1 = memory space, 0 = I/O space |
| req_addr | input | 20 | Transfer address |
| req_wdata | input | 16 | Write data |
| req_bhe | input | 1 | High-byte enable, active high |
| req_seg | input | 2 | Segment code shown on status lines |
| req_ready | output | 1 | Request can be taken this cycle |
| ad_out | output | 16 | Shared bus drive value |
| ad_oe | output | 1 | Shared bus output enable |
| ad_in | input | 16 | Shared bus sampled value |
| hi_out | output | 4 | Upper address / status lines |
| bhe_n | output | 1 | High-byte enable / status 7, active low |
| ale | output | 1 | Address latch enable |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| den_n | output | 1 | Data transceiver enable, active low |
| dt_r | output | 1 | Data direction, 1 = transmit |
| m_io | output | 1 | 1 = memory, 0 = I/O |
| ready | input | 1 | Wait-state control, high = proceed |
| rsp_data | output | 16 | Captured read data |
| rsp_done | output | 1 | Cycle completion pulse |

## Verification
Each cycle is run as a read or a write, to memory or to I/O, and with zero to several wait states. Read against write separates the strobe choice, the data-enable window and the bus turnaround. Memory against I/O, using addresses whose upper bits are nonzero, shows whether those bits are suppressed in T1. Varying the wait count, while `ready` is toggled in T1 and T2 and a decoy value sits on `ad_in` before the real one, shows that only the T3/TW edges are sampled and that read data is taken at the right edge. Back-to-back requests, all four segment codes and a fixed-seed random mix of these fields cover both the T4-to-T1 path and the status encoding.

// File: rtl/bseq_pkg.sv
package bseq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_T1   = 3'd1,
        ST_T2   = 3'd2,
        ST_T3   = 3'd3,
        ST_TW   = 3'd4,
        ST_T4   = 3'd5
    } bstate_t;

    // States in which ready is sampled at the closing edge
    function automatic logic is_sample_state(input bstate_t s);
        return (s == ST_T3) || (s == ST_TW);
    endfunction

endpackage

// File: rtl/bseq_fsm.sv
module bseq_fsm
    import bseq_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    req_valid,
    input  logic    ready,
    output bstate_t state,
    output logic    accept,
    output logic    take
);

    bstate_t nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: nxt = req_valid ? ST_T1 : ST_IDLE;
            ST_T1:   nxt = ST_T2;
            ST_T2:   nxt = ST_T3;
            ST_T3:   nxt = ready ? ST_T4 : ST_TW;
            ST_TW:   nxt = ready ? ST_T4 : ST_TW;
            ST_T4:   nxt = req_valid ? ST_T1 : ST_IDLE;
            default: nxt = ST_IDLE;
        endcase
    end

    assign accept = (state == ST_IDLE) || (state == ST_T4);
    assign take   = accept && req_valid;

endmodule

// File: rtl/bseq_latch.sv
module bseq_latch
    import bseq_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int DATA_W = 16,
    parameter int SEG_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  bstate_t           state,
    input  logic              ready,
    input  logic              take,
    input  logic              in_write,
    input  logic              in_mem,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic [DATA_W-1:0] in_wdata,
    input  logic              in_bhe,
    input  logic [SEG_W-1:0]  in_seg,
    input  logic [DATA_W-1:0] ad_in,
    output logic              q_write,
    output logic              q_mem,
    output logic [ADDR_W-1:0] q_addr,
    output logic [DATA_W-1:0] q_wdata,
    output logic              q_bhe,
    output logic [SEG_W-1:0]  q_seg,
    output logic [DATA_W-1:0] rdata
);

    logic capture;
    assign capture = is_sample_state(state) && ready && !q_write;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_write <= 1'b0;
            q_mem   <= 1'b0;
            q_addr  <= '0;
            q_wdata <= '0;
            q_bhe   <= 1'b0;
            q_seg   <= '0;
        end else if (take) begin
            q_write <= in_write;
            q_mem   <= in_mem;
            q_addr  <= in_addr;
            q_wdata <= in_wdata;
            q_bhe   <= in_bhe;
            q_seg   <= in_seg;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       rdata <= '0;
        else if (capture) rdata <= ad_in;
    end

endmodule

// File: rtl/bseq_pins.sv
module bseq_pins
    import bseq_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int DATA_W = 16,
    parameter int SEG_W  = 2
) (
    input  bstate_t                  state,
    input  logic                     q_write,
    input  logic                     q_mem,
    input  logic [ADDR_W-1:0]        q_addr,
    input  logic [DATA_W-1:0]        q_wdata,
    input  logic                     q_bhe,
    input  logic [SEG_W-1:0]         q_seg,
    output logic [DATA_W-1:0]        ad_out,
    output logic                     ad_oe,
    output logic [ADDR_W-DATA_W-1:0] hi_out,
    output logic                     bhe_n,
    output logic                     ale,
    output logic                     rd_n,
    output logic                     wr_n,
    output logic                     den_n,
    output logic                     dt_r,
    output logic                     m_io,
    output logic                     done
);

    localparam int HI_W = ADDR_W - DATA_W;

    logic [HI_W-1:0] status_bits;
    assign status_bits = {{(HI_W-SEG_W){1'b0}}, q_seg};

    always_comb begin
        ad_out = q_wdata;
        ad_oe  = 1'b0;
        hi_out = status_bits;
        bhe_n  = 1'b1;
        ale    = 1'b0;
        rd_n   = 1'b1;
        wr_n   = 1'b1;
        den_n  = 1'b1;
        dt_r   = q_write;
        m_io   = q_mem;
        done   = 1'b0;
        unique case (state)
            ST_IDLE: begin
                hi_out = '0;
                dt_r   = 1'b0;
                m_io   = 1'b0;
            end
            ST_T1: begin
                ale    = 1'b1;
                ad_oe  = 1'b1;
                ad_out = q_addr[DATA_W-1:0];
                hi_out = q_mem ? q_addr[ADDR_W-1:DATA_W] : '0;
                bhe_n  = !q_bhe;
            end
            ST_T2: begin
                ad_oe = q_write;
                rd_n  = q_write;
                wr_n  = !q_write;
                den_n = !q_write;
            end
            ST_T3, ST_TW: begin
                ad_oe = q_write;
                rd_n  = q_write;
                wr_n  = !q_write;
                den_n = 1'b0;
            end
            ST_T4: begin
                ad_oe = q_write;
                den_n = 1'b0;
                done  = 1'b1;
            end
            default: begin
                hi_out = '0;
                dt_r   = 1'b0;
                m_io   = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/bus_cycle_seq.sv
module bus_cycle_seq
    import bseq_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int DATA_W = 16,
    parameter int SEG_W  = 2,
    localparam int HI_W  = ADDR_W - DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic              req_mem,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              req_bhe,
    input  logic [SEG_W-1:0]  req_seg,
    output logic              req_ready,
    output logic [DATA_W-1:0] ad_out,
    output logic              ad_oe,
    input  logic [DATA_W-1:0] ad_in,
    output logic [HI_W-1:0]   hi_out,
    output logic              bhe_n,
    output logic              ale,
    output logic              rd_n,
    output logic              wr_n,
    output logic              den_n,
    output logic              dt_r,
    output logic              m_io,
    input  logic              ready,
    output logic [DATA_W-1:0] rsp_data,
    output logic              rsp_done
);

    bstate_t           state;
    logic              take;
    logic              q_write, q_mem, q_bhe;
    logic [ADDR_W-1:0] q_addr;
    logic [DATA_W-1:0] q_wdata;
    logic [SEG_W-1:0]  q_seg;

    bseq_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .ready     (ready),
        .state     (state),
        .accept    (req_ready),
        .take      (take)
    );

    bseq_latch #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SEG_W(SEG_W)) u_latch (
        .clk      (clk),
        .rst_n    (rst_n),
        .state    (state),
        .ready    (ready),
        .take     (take),
        .in_write (req_write),
        .in_mem   (req_mem),
        .in_addr  (req_addr),
        .in_wdata (req_wdata),
        .in_bhe   (req_bhe),
        .in_seg   (req_seg),
        .ad_in    (ad_in),
        .q_write  (q_write),
        .q_mem    (q_mem),
        .q_addr   (q_addr),
        .q_wdata  (q_wdata),
        .q_bhe    (q_bhe),
        .q_seg    (q_seg),
        .rdata    (rsp_data)
    );

    bseq_pins #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SEG_W(SEG_W)) u_pins (
        .state   (state),
        .q_write (q_write),
        .q_mem   (q_mem),
        .q_addr  (q_addr),
        .q_wdata (q_wdata),
        .q_bhe   (q_bhe),
        .q_seg   (q_seg),
        .ad_out  (ad_out),
        .ad_oe   (ad_oe),
        .hi_out  (hi_out),
        .bhe_n   (bhe_n),
        .ale     (ale),
        .rd_n    (rd_n),
        .wr_n    (wr_n),
        .den_n   (den_n),
        .dt_r    (dt_r),
        .m_io    (m_io),
        .done    (rsp_done)
    );

endmodule

// File: rtl/bseq_chk.sv
module bseq_chk (
    input logic clk,
    input logic rst_n,
    input logic req_ready,
    input logic ad_oe,
    input logic ale,
    input logic rd_n,
    input logic wr_n,
    input logic den_n,
    input logic dt_r,
    input logic m_io,
    input logic ready,
    input logic rsp_done
);

    assert_ale_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ale |=> !ale);

    assert_ale_drives_bus_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ale |-> ad_oe);

    assert_strobe_exclusive_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(!rd_n && !wr_n));

    assert_read_strobe_after_ale_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ale && !dt_r) |=> !rd_n);

    assert_wait_holds_strobe_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_n && !ready) |=> !rd_n);

    assert_read_bus_released_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!dt_r && !ale) |-> !ad_oe);

    assert_space_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_n || !wr_n) |-> $stable(m_io));

    assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> !rsp_done);

    assert_done_with_den_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |-> !den_n);

    assert_done_accepts_R1: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |-> req_ready);

endmodule

bind bus_cycle_seq bseq_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_ready (req_ready),
    .ad_oe     (ad_oe),
    .ale       (ale),
    .rd_n      (rd_n),
    .wr_n      (wr_n),
    .den_n     (den_n),
    .dt_r      (dt_r),
    .m_io      (m_io),
    .ready     (ready),
    .rsp_done  (rsp_done)
);

// File: tb/bus_cycle_seq_tb.sv
module bus_cycle_seq_tb;

    localparam int PH_IDLE = 0, PH_T1 = 1, PH_T2 = 2, PH_T3 = 3, PH_TW = 4, PH_T4 = 5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0, req_mem = 1'b0, req_bhe = 1'b0;
    logic [19:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic [1:0]  req_seg = '0;
    logic        req_ready;
    logic [15:0] ad_out, ad_in = '0, rsp_data;
    logic        ad_oe, bhe_n, ale, rd_n, wr_n, den_n, dt_r, m_io, rsp_done;
    logic [3:0]  hi_out;
    logic        ready = 1'b1;

    int checks = 0;
    int failures = 0;
    logic [15:0] exp_rdata = '0;

    always #2 clk = ~clk;

    bus_cycle_seq u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_mem(req_mem), .req_addr(req_addr), .req_wdata(req_wdata),
        .req_bhe(req_bhe), .req_seg(req_seg), .req_ready(req_ready),
        .ad_out(ad_out), .ad_oe(ad_oe), .ad_in(ad_in), .hi_out(hi_out),
        .bhe_n(bhe_n), .ale(ale), .rd_n(rd_n), .wr_n(wr_n), .den_n(den_n),
        .dt_r(dt_r), .m_io(m_io), .ready(ready), .rsp_data(rsp_data),
        .rsp_done(rsp_done)
    );

    task automatic chk(input string tag, input logic [19:0] act, input logic [19:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [3:0] exp_hi(input int ph, input logic mem,
                                          input logic [19:0] a, input logic [1:0] s);
        if (ph == PH_IDLE) return 4'h0;
        if (ph == PH_T1)   return mem ? a[19:16] : 4'h0;
        return {2'b00, s};
    endfunction

    function automatic logic exp_den_n(input int ph, input logic wr);
        if (ph == PH_IDLE || ph == PH_T1) return 1'b1;
        if (ph == PH_T2) return !wr;
        return 1'b0;
    endfunction

    task automatic check_pins(input int ph, input logic wr, input logic mem,
                              input logic [19:0] a, input logic [15:0] wd,
                              input logic bhe, input logic [1:0] s);
        logic strobe_ph;
        strobe_ph = (ph == PH_T2) || (ph == PH_T3) || (ph == PH_TW);
        chk("R2 ale", ale, ph == PH_T1);
        chk("R8 ad_oe", ad_oe, (ph == PH_T1) || (wr && ph >= PH_T2));
        if (ph == PH_T1) chk("R2 ad_out address", ad_out, a[15:0]);
        else if (wr && ph >= PH_T2) chk("R8 ad_out write data", ad_out, wd);
        chk("R3 hi_out", hi_out, exp_hi(ph, mem, a, s));
        chk("R4 bhe_n", bhe_n, (ph == PH_T1) ? !bhe : 1'b1);
        chk("R5 rd_n", rd_n, !(!wr && strobe_ph && ph != PH_IDLE));
        chk("R5 wr_n", wr_n, !(wr && strobe_ph && ph != PH_IDLE));
        chk("R6 den_n", den_n, exp_den_n(ph, wr));
        chk("R7 dt_r", dt_r, (ph != PH_IDLE) && wr);
        chk("R7 m_io", m_io, (ph != PH_IDLE) && mem);
        chk("R11 rsp_done", rsp_done, ph == PH_T4);
        chk("R1 req_ready", req_ready, (ph == PH_IDLE) || (ph == PH_T4));
    endtask

    // Entered at a falling edge where the design is in IDLE or T4.
    // Returns at the falling edge inside T4.
    task automatic do_cycle(input logic wr, input logic mem, input logic [19:0] a,
                            input logic [15:0] wd, input logic bhe, input logic [1:0] s,
                            input int waits, input logic [15:0] rdv, input bit b2b);
        req_valid = 1'b1; req_write = wr; req_mem = mem; req_addr = a;
        req_wdata = wd; req_bhe = bhe; req_seg = s;
        @(negedge clk);
        req_valid = 1'b0;
        req_addr = ~a; req_wdata = ~wd; req_write = !wr; req_mem = !mem;
        if (b2b) chk("R12 back-to-back T1", ale, 1'b1);
        check_pins(PH_T1, wr, mem, a, wd, bhe, s);
        ready = 1'b0; ad_in = ~rdv;          // ignored in T1 (R9)
        @(negedge clk);
        check_pins(PH_T2, wr, mem, a, wd, bhe, s);
        ready = 1'b1; ad_in = ~rdv;          // ignored in T2 (R9)
        @(negedge clk);
        check_pins(PH_T3, wr, mem, a, wd, bhe, s);
        ready = (waits == 0); ad_in = (waits == 0) ? rdv : ~rdv;
        for (int k = 1; k <= waits; k++) begin
            @(negedge clk);
            chk("R9 wait state strobes", {rd_n, wr_n}, wr ? 2'b10 : 2'b01);
            check_pins(PH_TW, wr, mem, a, wd, bhe, s);
            ready = (k == waits); ad_in = (k == waits) ? rdv : ~rdv;
        end
        @(negedge clk);
        if (!wr) exp_rdata = rdv;
        check_pins(PH_T4, wr, mem, a, wd, bhe, s);
        chk("R10 rsp_data in T4", rsp_data, exp_rdata);
        ready = 1'b1; ad_in = ~rdv;
    endtask

    task automatic idle_step();
        @(negedge clk);
        check_pins(PH_IDLE, 1'b0, 1'b0, 20'h0, 16'h0, 1'b0, 2'b00);
        chk("R10 rsp_data held", rsp_data, exp_rdata);
    endtask

    initial begin
        #(4 * 150000);
        failures++;
        $display("FAIL watchdog expired");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EB0_1234));
        repeat (3) @(negedge clk);
        check_pins(PH_IDLE, 1'b0, 1'b0, 20'h0, 16'h0, 1'b0, 2'b00);
        chk("R10 rsp_data reset", rsp_data, 16'h0);
        rst_n = 1'b1;
        idle_step();

        // Directed corners
        do_cycle(1'b0, 1'b1, 20'hA1234, 16'h0, 1'b1, 2'b00, 0, 16'hBEEF, 1'b0);
        idle_step();
        do_cycle(1'b1, 1'b1, 20'hF5678, 16'hC0DE, 1'b0, 2'b01, 2, 16'h0, 1'b0);
        idle_step();
        do_cycle(1'b0, 1'b0, 20'h9ABCD, 16'h0, 1'b1, 2'b10, 1, 16'h1357, 1'b0);
        do_cycle(1'b1, 1'b0, 20'h7FFFF, 16'h2468, 1'b1, 2'b11, 0, 16'h0, 1'b1);
        do_cycle(1'b0, 1'b1, 20'h00001, 16'h0, 1'b0, 2'b11, 3, 16'h8001, 1'b1);
        idle_step();
        do_cycle(1'b1, 1'b1, 20'h3C3C3, 16'hFFFF, 1'b1, 2'b00, 5, 16'h0, 1'b0);
        idle_step();

        // Fixed-seed random mix
        for (int n = 0; n < 80; n++) begin
            logic        wr, mem, bhe, b2b_next;
            logic [19:0] a;
            logic [15:0] wd, rdv;
            logic [1:0]  s;
            int          waits;
            wr = 1'($urandom); mem = 1'($urandom); bhe = 1'($urandom);
            a = 20'($urandom); wd = 16'($urandom); rdv = 16'($urandom);
            s = 2'($urandom); waits = int'($urandom % 4);
            b2b_next = 1'($urandom);
            do_cycle(wr, mem, a, wd, bhe, s, waits, rdv, (n > 0) && b2b_next);
            if (($urandom % 2) == 0) idle_step();
        end
        idle_step();

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule